// File: doc/BRIEF.md
# Floating-Point Unit Status and Control Word Unit

This block holds the two architectural words that sit beside a floating-point coprocessor's arithmetic core. The control word is loaded through one write port. It carries six exception mask bits, a precision selector, a rounding selector and an infinity-mode bit. The block decodes the selectors into one-hot strobes that the arithmetic datapath consumes directly.

The status word gathers six sticky exception flags, set by single-cycle pulses from the arithmetic unit and cleared only by an explicit strobe. It also holds four condition code bits, a three-bit register-stack top pointer that can be loaded, pushed or popped, and a busy bit that follows the core's busy line. An error summary is formed from every flag whose mask bit is clear. That summary appears in the status word and also drives the interrupt request, so a host can either poll the word or take the interrupt.

Top module: `fpu_ctrl_status`

## Requirements
- R1: While rst_ni is low, cw_o equals CW_RST & 16'h1F3F, sw_o holds TOP_RST in bits 13:11 and zero in every other bit, and irq_o is 0.
- R2: When cw_we_i is high at a clock edge, cw_o equals cw_wdata_i & 16'h1F3F from the next cycle on. Bits 7:6 and 15:13 always read 0. Masks are in bits 5:0, PC in 9:8, RC in 11:10 and IC in bit 12.
- R3: Exception flags sit in sw_o[5:0] and are sticky. Each cycle, exc_set_i is ORed into them, and a flag that is set stays set until a clear strobe arrives.
- R4: When exc_clr_i is high at an edge, sw_o[5:0] becomes exactly exc_set_i of that same edge, so a set pulse that coincides with a clear survives it.
- R5: The error summary sw_o[7] and irq_o both equal the OR of (sw_o[5:0] & ~cw_o[5:0]) in every cycle. Clearing the mask of a flag that is already set raises irq_o in the same cycle as the new control word appears.
- R6: round_sel_o is one-hot, with bit k set for RC code k: 0 = nearest-even, 1 = toward minus infinity, 2 = toward plus infinity, 3 = toward zero.
- R7: prec_sel_o is 3'b001 for PC 00 (single), 3'b010 for PC 10 (double) and 3'b100 for PC 11 (extended). For the reserved PC 01, prec_sel_o is 3'b000, invalid_pc_o is 1 and the field reads back as 01.
- R8: inf_affine_o equals control bit 12, where 1 means affine and 0 means projective.
- R9: When cc_we_i is high at an edge, cc_wdata_i bits 0, 1, 2 and 3 (C0 to C3) appear at sw_o bits 8, 9, 10 and 14 in the next cycle. Otherwise they hold.
- R10: The stack top sw_o[13:11] loads top_wdata_i when top_we_i is high. Otherwise it decrements modulo 8 on top_push_i alone, increments modulo 8 on top_pop_i alone, and holds when both or neither are high.
- R11: sw_o[15] equals busy_i as sampled at the previous clock edge, and sw_o[6] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cw_we_i | input | 1 | Load control word |
| cw_wdata_i | input | 16 | Control word value to load |
| exc_set_i | input | 6 | Exception set pulses from the arithmetic unit |
| exc_clr_i | input | 1 | Clear all exception flags |
| cc_we_i | input | 1 | Write condition codes |
| cc_wdata_i | input | 4 | Condition codes {C3,C2,C1,C0} |
| top_we_i | input | 1 | Load stack top |
| top_wdata_i | input | 3 | Stack top value to load |
| top_push_i | input | 1 | Decrement stack top |
| top_pop_i | input | 1 | Increment stack top |
| busy_i | input | 1 | Core busy indication |
| cw_o | output | 16 | Control word read port |
| sw_o | output | 16 | Status word read port |
| irq_o | output | 1 | Interrupt request (error summary) |
| round_sel_o | output | 4 | One-hot rounding mode |
| prec_sel_o | output | 3 | One-hot precision {ext,dbl,sgl} |
| inf_affine_o | output | 1 | Affine infinity mode |
| invalid_pc_o | output | 1 | Reserved precision code is held |

## Verification
The bench builds the block with CW_RST = 16'h1B3F and TOP_RST = 3'd5. With these values the reset state already selects rounding toward plus infinity, affine infinity and a nonzero stack top, so any field that is wrongly cleared at reset shows up. Starting from 5 also means the push and pop sequences cross both wrap points, 0 to 7 and 7 to 0, within a few cycles. Every combination of RC and PC is written, including the reserved code. The stimulus also unmasks flags that are already set and sends clear strobes that coincide with set pulses.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int EXC_W = 6;
  localparam int WORD_W = 16;
  localparam int TOP_W = 3;
  localparam int CC_W = 4;
  localparam int RND_N = 4;
  localparam int PREC_N = 3;
  localparam logic [WORD_W-1:0] CW_WR_MASK = 16'h1F3F;

  // control word field positions
  localparam int CW_PC_LO = 8;
  localparam int CW_RC_LO = 10;
  localparam int CW_IC = 12;

  // status word field positions
  localparam int SW_ES = 7;
  localparam int SW_C0 = 8;
  localparam int SW_C1 = 9;
  localparam int SW_C2 = 10;
  localparam int SW_TOP_LO = 11;
  localparam int SW_C3 = 14;
  localparam int SW_B = 15;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_DOWN = 2'd1,
    RND_UP   = 2'd2,
    RND_ZERO = 2'd3
  } rnd_e;

  typedef enum logic [1:0] {
    PREC_SGL = 2'd0,
    PREC_RSV = 2'd1,
    PREC_DBL = 2'd2,
    PREC_EXT = 2'd3
  } prec_e;

  typedef struct packed {
    logic             affine;
    rnd_e             rnd;
    prec_e            prec;
    logic [EXC_W-1:0] mask;
  } cw_t;
endpackage

// File: rtl/fcs_ctrl_word.sv
module fcs_ctrl_word
  import fcs_pkg::*;
#(
  parameter logic [WORD_W-1:0] CW_RST = 16'h033F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output cw_t               cw_o,
  output logic [WORD_W-1:0] cw_bits_o,
  output logic [RND_N-1:0]  round_sel_o,
  output logic [PREC_N-1:0] prec_sel_o,
  output logic              inf_affine_o,
  output logic              invalid_pc_o
);
  function automatic cw_t unpack_cw(logic [WORD_W-1:0] w);
    cw_t c;
    c.mask   = w[EXC_W-1:0];
    c.prec   = prec_e'(w[CW_PC_LO +: 2]);
    c.rnd    = rnd_e'(w[CW_RC_LO +: 2]);
    c.affine = w[CW_IC];
    return c;
  endfunction

  localparam cw_t RST_CW = unpack_cw(CW_RST);

  cw_t cw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cw_q <= RST_CW;
    else if (we_i) cw_q <= unpack_cw(wdata_i);
  end

  always_comb begin
    cw_bits_o = '0;
    cw_bits_o[EXC_W-1:0]     = cw_q.mask;
    cw_bits_o[CW_PC_LO +: 2] = cw_q.prec;
    cw_bits_o[CW_RC_LO +: 2] = cw_q.rnd;
    cw_bits_o[CW_IC]         = cw_q.affine;
  end

  for (genvar i = 0; i < RND_N; i++) begin : g_rnd
    assign round_sel_o[i] = (cw_q.rnd == rnd_e'(i));
  end

  assign prec_sel_o[0] = (cw_q.prec == PREC_SGL);
  assign prec_sel_o[1] = (cw_q.prec == PREC_DBL);
  assign prec_sel_o[2] = (cw_q.prec == PREC_EXT);
  assign invalid_pc_o  = (cw_q.prec == PREC_RSV);
  assign inf_affine_o  = cw_q.affine;
  assign cw_o          = cw_q;
endmodule

// File: rtl/fcs_exc_sticky.sv
module fcs_exc_sticky
  import fcs_pkg::*;
#(
  parameter int N = EXC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         es_o
);
  logic [N-1:0] flag_q;
  logic [N-1:0] live;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // a set pulse wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i)    flag_q[i] <= 1'b0;
    end
    assign live[i] = flag_q[i] & ~mask_i[i];
  end

  assign flags_o = flag_q;
  assign es_o    = |live;
endmodule

// File: rtl/fcs_stack_top.sv
module fcs_stack_top
  import fcs_pkg::*;
#(
  parameter int             W   = TOP_W,
  parameter logic [W-1:0]   RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         push_i,
  input  logic         pop_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] top_q, top_d;

  always_comb begin
    top_d = top_q;
    if (we_i)                 top_d = wdata_i;
    else if (push_i && !pop_i) top_d = top_q - W'(1);
    else if (pop_i && !push_i) top_d = top_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) top_q <= RST;
    else         top_q <= top_d;
  end

  assign top_o = top_q;
endmodule

// File: rtl/fpu_ctrl_status.sv
module fpu_ctrl_status
  import fcs_pkg::*;
#(
  parameter logic [WORD_W-1:0] CW_RST  = 16'h033F,
  parameter logic [TOP_W-1:0]  TOP_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_we_i,
  input  logic [WORD_W-1:0] cw_wdata_i,
  input  logic [EXC_W-1:0]  exc_set_i,
  input  logic              exc_clr_i,
  input  logic              cc_we_i,
  input  logic [CC_W-1:0]   cc_wdata_i,
  input  logic              top_we_i,
  input  logic [TOP_W-1:0]  top_wdata_i,
  input  logic              top_push_i,
  input  logic              top_pop_i,
  input  logic              busy_i,
  output logic [WORD_W-1:0] cw_o,
  output logic [WORD_W-1:0] sw_o,
  output logic              irq_o,
  output logic [RND_N-1:0]  round_sel_o,
  output logic [PREC_N-1:0] prec_sel_o,
  output logic              inf_affine_o,
  output logic              invalid_pc_o
);
  cw_t              cw;
  logic [EXC_W-1:0] flags;
  logic             es;
  logic [TOP_W-1:0] top;
  logic [CC_W-1:0]  cc_q;
  logic             busy_q;

  fcs_ctrl_word #(.CW_RST(CW_RST)) u_cw (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cw_we_i),
    .wdata_i      (cw_wdata_i),
    .cw_o         (cw),
    .cw_bits_o    (cw_o),
    .round_sel_o  (round_sel_o),
    .prec_sel_o   (prec_sel_o),
    .inf_affine_o (inf_affine_o),
    .invalid_pc_o (invalid_pc_o)
  );

  fcs_exc_sticky #(.N(EXC_W)) u_exc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (exc_set_i),
    .clr_i   (exc_clr_i),
    .mask_i  (cw.mask),
    .flags_o (flags),
    .es_o    (es)
  );

  fcs_stack_top #(.W(TOP_W), .RST(TOP_RST)) u_top (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (top_we_i),
    .wdata_i (top_wdata_i),
    .push_i  (top_push_i),
    .pop_i   (top_pop_i),
    .top_o   (top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      if (cc_we_i) cc_q <= cc_wdata_i;
      busy_q <= busy_i;
    end
  end

  always_comb begin
    sw_o = '0;
    sw_o[EXC_W-1:0]          = flags;
    sw_o[SW_ES]              = es;
    sw_o[SW_C0]              = cc_q[0];
    sw_o[SW_C1]              = cc_q[1];
    sw_o[SW_C2]              = cc_q[2];
    sw_o[SW_TOP_LO +: TOP_W] = top;
    sw_o[SW_C3]              = cc_q[3];
    sw_o[SW_B]               = busy_q;
  end

  assign irq_o = es;
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cw_we_i,
  input logic [15:0] cw_wdata_i,
  input logic [5:0]  exc_set_i,
  input logic        exc_clr_i,
  input logic        top_we_i,
  input logic        top_push_i,
  input logic        top_pop_i,
  input logic        busy_i,
  input logic [15:0] cw_o,
  input logic [15:0] sw_o,
  input logic        irq_o,
  input logic [3:0]  round_sel_o,
  input logic [2:0]  prec_sel_o,
  input logic        invalid_pc_o
);
  // R2
  cw_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_we_i |=> cw_o == ($past(cw_wdata_i) & 16'h1F3F));

  // R3
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_clr_i |=> ((sw_o[5:0] & $past(sw_o[5:0])) == $past(sw_o[5:0])));

  // R4
  clr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_clr_i |=> sw_o[5:0] == $past(exc_set_i));

  // R5
  irq_es_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == sw_o[7]) && (irq_o == |(sw_o[5:0] & ~cw_o[5:0])));

  // R6
  round_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(round_sel_o) == 1) && round_sel_o[cw_o[11:10]]);

  // R7
  prec_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prec_sel_o) && (invalid_pc_o == (cw_o[9:8] == 2'b01)));

  // R7
  prec_rsv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_pc_o |-> prec_sel_o == 3'b000);

  // R10
  top_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!top_we_i && top_push_i && !top_pop_i) |=> sw_o[13:11] == 3'($past(sw_o[13:11]) - 3'd1));

  // R10
  top_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!top_we_i && top_pop_i && !top_push_i) |=> sw_o[13:11] == 3'($past(sw_o[13:11]) + 3'd1));

  // R11
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sw_o[15] == $past(busy_i)) && !sw_o[6]);
endmodule

bind fpu_ctrl_status fcs_chk u_fcs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cw_we_i      (cw_we_i),
  .cw_wdata_i   (cw_wdata_i),
  .exc_set_i    (exc_set_i),
  .exc_clr_i    (exc_clr_i),
  .top_we_i     (top_we_i),
  .top_push_i   (top_push_i),
  .top_pop_i    (top_pop_i),
  .busy_i       (busy_i),
  .cw_o         (cw_o),
  .sw_o         (sw_o),
  .irq_o        (irq_o),
  .round_sel_o  (round_sel_o),
  .prec_sel_o   (prec_sel_o),
  .invalid_pc_o (invalid_pc_o)
);

// File: tb/fpu_ctrl_status_bench.sv
`timescale 1ns/1ps
module fpu_ctrl_status_bench;
  localparam logic [15:0] P_CW_RST  = 16'h1B3F;
  localparam logic [2:0]  P_TOP_RST = 3'd5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cw_we = 1'b0;
  logic [15:0] cw_wdata = '0;
  logic [5:0]  exc_set = '0;
  logic        exc_clr = 1'b0;
  logic        cc_we = 1'b0;
  logic [3:0]  cc_wdata = '0;
  logic        top_we = 1'b0;
  logic [2:0]  top_wdata = '0;
  logic        top_push = 1'b0;
  logic        top_pop = 1'b0;
  logic        busy = 1'b0;

  logic [15:0] cw_o, sw_o;
  logic        irq_o, inf_affine_o, invalid_pc_o;
  logic [3:0]  round_sel_o;
  logic [2:0]  prec_sel_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fpu_ctrl_status #(.CW_RST(P_CW_RST), .TOP_RST(P_TOP_RST)) u_fpu_ctrl_status (
    .clk_i(clk), .rst_ni(rst_ni), .cw_we_i(cw_we), .cw_wdata_i(cw_wdata),
    .exc_set_i(exc_set), .exc_clr_i(exc_clr), .cc_we_i(cc_we), .cc_wdata_i(cc_wdata),
    .top_we_i(top_we), .top_wdata_i(top_wdata), .top_push_i(top_push), .top_pop_i(top_pop),
    .busy_i(busy), .cw_o(cw_o), .sw_o(sw_o), .irq_o(irq_o), .round_sel_o(round_sel_o),
    .prec_sel_o(prec_sel_o), .inf_affine_o(inf_affine_o), .invalid_pc_o(invalid_pc_o)
  );

  // behavioural reference state
  logic [15:0] m_cw;
  logic [5:0]  m_flags;
  logic [3:0]  m_cc;
  int          m_top;
  logic        m_busy;
  bit          m_was_clr;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cw = P_CW_RST & 16'h1F3F;
      m_flags = '0; m_cc = '0; m_top = P_TOP_RST; m_busy = 1'b0; m_was_clr = 1'b0;
    end else begin
      if (cw_we) m_cw = cw_wdata & 16'h1F3F;
      m_flags = exc_clr ? exc_set : (m_flags | exc_set);
      m_was_clr = exc_clr;
      if (cc_we) m_cc = cc_wdata;
      if (top_we) m_top = top_wdata;
      else if (top_push && !top_pop) m_top = (m_top + 7) % 8;
      else if (top_pop && !top_push) m_top = (m_top + 1) % 8;
      m_busy = busy;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [15:0] e_sw;
      logic        e_es;
      logic [2:0]  e_prec;
      bit          r = !rst_ni;
      e_es = |(m_flags & ~m_cw[5:0]);
      e_sw = '0;
      e_sw[5:0] = m_flags;
      e_sw[7] = e_es;
      e_sw[8] = m_cc[0]; e_sw[9] = m_cc[1]; e_sw[10] = m_cc[2]; e_sw[14] = m_cc[3];
      e_sw[13:11] = 3'(m_top);
      e_sw[15] = m_busy;
      case (m_cw[9:8])
        2'b00: e_prec = 3'b001;
        2'b01: e_prec = 3'b000;
        2'b10: e_prec = 3'b010;
        default: e_prec = 3'b100;
      endcase
      chk(r ? "R1" : "R2", "cw_o", 32'(cw_o), 32'(m_cw));
      chk(r ? "R1" : (m_was_clr ? "R4" : "R3"), "flags", 32'(sw_o[5:0]), 32'(e_sw[5:0]));
      chk(r ? "R1" : "R5", "es/irq", 32'({sw_o[7], irq_o}), 32'({e_es, e_es}));
      chk(r ? "R1" : "R6", "round_sel", 32'(round_sel_o), 32'(4'b0001 << m_cw[11:10]));
      chk(r ? "R1" : "R7", "prec", 32'({invalid_pc_o, prec_sel_o}),
          32'({m_cw[9:8] == 2'b01, e_prec}));
      chk(r ? "R1" : "R8", "affine", 32'(inf_affine_o), 32'(m_cw[12]));
      chk(r ? "R1" : "R9", "cc", 32'({sw_o[14], sw_o[10:8]}), 32'({e_sw[14], e_sw[10:8]}));
      chk(r ? "R1" : "R10", "top", 32'(sw_o[13:11]), 32'(e_sw[13:11]));
      chk(r ? "R1" : "R11", "busy/bit6", 32'({sw_o[15], sw_o[6]}), 32'({e_sw[15], 1'b0}));
    end
  end

  task automatic idle_inputs();
    cw_we = 0; exc_set = '0; exc_clr = 0; cc_we = 0; top_we = 0; top_push = 0; top_pop = 0;
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
    idle_inputs();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);           // R1 reset state observed
    rst_ni = 1'b1;
    step(2);
    // R2: reserved bits read zero
    cw_we = 1; cw_wdata = 16'hFFFF; step(2);
    // R6 R7 R8: every RC/PC pair
    for (int rc = 0; rc < 4; rc++)
      for (int pc = 0; pc < 4; pc++) begin
        cw_we = 1; cw_wdata = {3'b000, 1'(rc & 1), 2'(rc), 2'(pc), 8'h3F};
        step(2);
      end
    // R3 R5: flag masked, then unmask raises irq
    cw_we = 1; cw_wdata = 16'h033F; step();
    exc_set = 6'b000100; step(3);
    cw_we = 1; cw_wdata = 16'h033B; step(2);
    exc_set = 6'b100000; step(2);
    // R4: clear alone, then clear with coincident set
    exc_clr = 1; step(2);
    exc_set = 6'b000011; step();
    exc_clr = 1; exc_set = 6'b010000; step(2);
    // R9
    cc_we = 1; cc_wdata = 4'b1010; step();
    cc_we = 1; cc_wdata = 4'b0101; step(2);
    // R10: wrap both ways from reset value
    for (int i = 0; i < 7; i++) begin top_push = 1; step(); end
    for (int i = 0; i < 9; i++) begin top_pop = 1; step(); end
    top_push = 1; top_pop = 1; step();
    top_we = 1; top_wdata = 3'd2; top_push = 1; step(2);
    // R11
    busy = 1; step(2); busy = 0; step(); busy = 1; step(); busy = 0; step(2);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      cw_we = ($urandom % 8) == 0; cw_wdata = 16'($urandom);
      exc_set = (($urandom % 4) == 0) ? 6'(1 << ($urandom % 6)) : 6'b0;
      exc_clr = ($urandom % 16) == 0;
      cc_we = ($urandom % 6) == 0; cc_wdata = 4'($urandom);
      top_we = ($urandom % 20) == 0; top_wdata = 3'($urandom);
      top_push = ($urandom % 3) == 0; top_pop = ($urandom % 3) == 0;
      busy = 1'($urandom);
      @(negedge clk);
    end
    idle_inputs();
    step(3);
    finish_run();
  end
endmodule